// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block serialises bytes onto an asynchronous transmit line. A single holding register sits in front of the frame shift register, so software can hand over the next byte while the current one is still on the wire. Consecutive bytes then leave with exactly one stop bit between them and no idle gap. Every frame has one low start bit, the data bits least significant first, and one high stop bit. Each bit lasts a fixed number of baud ticks supplied from outside.

With buffering enabled, the transmit interrupt flag means "the holding register can take another byte", not "a frame has finished". Two inputs select how the flag behaves. The first places the event either where the stop bit of the current frame begins or where it ends. The second chooses whether one final event is raised after the last queued byte. With buffering disabled, the block acts as a plain transmitter: each write starts one frame, and the flag is raised when that frame is complete. The flag is level-held until software clears it.

Top module: `dbuf_uart_tx`

## Requirements
- R1: With buffering on, a write while the block is not busy loads the shifter directly. The start bit appears on the cycle after the write, and the interrupt flag is set on that same cycle.
- R2: The line idles high. A frame is one start bit (0), DATA_W data bits with bit 0 first, and one stop bit (1). Each bit lasts OVS baud ticks.
- R3: A byte queued at any point before the current stop bit ends starts with its start bit on the first tick after that stop bit, with no extra idle time.
- R4: With the position select at 0, a byte waiting in the holding register is taken into the shifter when the current stop bit begins. The flag is set on that cycle, and the frame still starts only after the stop bit ends.
- R5: With the position select at 1, a waiting byte is taken into the shifter when the current stop bit ends, and the flag is set on that cycle.
- R6: With buffering on and the last-byte select at 0, no flag event follows the last byte once nothing is waiting.
- R7: With the last-byte select at 1 and nothing waiting, one final flag event is raised at the beginning (position 0) or end (position 1) of the last frame's stop bit.
- R8: With buffering off, a write while idle starts a frame, and the flag is set only when that frame's stop bit ends. A write while busy is dropped, and the overrun output pulses.
- R9: A write landing in the very cycle the last stop bit ends, with the last-byte select at 1, is loaded and sent back to back. It produces a single flag event.
- R10: The flag stays set until the clear input is asserted. A set and a clear in the same cycle leave it set.
- R11: A write while the holding register is full replaces the held byte. The overrun output is high for the one cycle after that write.
- R12: Reset empties the holding register, stops the shifter, drives the line high and clears the flag. Busy is high while a frame is being sent or a byte is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for one byte |
| wr_data | input | DATA_W | Byte to transmit |
| baud_tick | input | 1 | Baud-rate tick; OVS ticks per bit |
| dbuf_en | input | 1 | 1 enables the holding register and its interrupt meaning |
| last_irq_en | input | 1 | 1 raises a final flag event after the last byte |
| irq_at_end | input | 1 | 0: event at stop-bit start, 1: at stop-bit end |
| irq_clr | input | 1 | Clears the interrupt flag |
| txd | output | 1 | Serial line, idles high |
| tx_irq | output | 1 | Transmit interrupt flag |
| busy | output | 1 | Frame in progress or byte held |
| overrun | output | 1 | One-cycle pulse on an overwritten or dropped byte |

## Verification
The bench builds the block with DATA_W=8, OVS=16 and the holding register present, and holds baud_tick high. Every bit is therefore exactly sixteen clocks long, and stop-bit boundaries fall on predictable cycles. This lets the bench compare each flag rising edge against the frame starts it decodes from the line, for all four combinations of position select and last-byte select. It also lets it place a write exactly on the cycle a stop bit ends. Random byte values and random string lengths from a fixed seed are mixed with directed overrun, plain-mode and set/clear collision cases.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

   typedef enum logic [1:0] {
      TXS_IDLE  = 2'd0,
      TXS_START = 2'd1,
      TXS_DATA  = 2'd2,
      TXS_STOP  = 2'd3
   } tx_state_e;

endpackage

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
   import uart_tx_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OVS    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              go,
   input  logic              arm,
   input  logic [DATA_W-1:0] ld_data,
   output logic              txd,
   output logic              idle,
   output logic              stop_begin,
   output logic              stop_end,
   output logic              armed
);

   localparam int CNT_W = (OVS > 1) ? $clog2(OVS) : 1;
   localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_W - 1);

   tx_state_e         state_q, state_d;
   logic [CNT_W-1:0]  cnt_q, cnt_d;
   logic [IDX_W-1:0]  idx_q, idx_d;
   logic [DATA_W-1:0] sh_q, sh_d;
   logic              armed_q, armed_d;
   logic              bit_done;

   assign bit_done   = tick && (cnt_q == CNT_LAST);
   assign stop_begin = (state_q == TXS_DATA) && bit_done && (idx_q == IDX_LAST);
   assign stop_end   = (state_q == TXS_STOP) && bit_done;
   assign idle       = (state_q == TXS_IDLE);
   assign armed      = armed_q;

   always_comb begin
      unique case (state_q)
         TXS_START: txd = 1'b0;
         TXS_DATA:  txd = sh_q[0];
         default:   txd = 1'b1;
      endcase
   end

   always_comb begin
      state_d = state_q;
      cnt_d   = cnt_q;
      idx_d   = idx_q;
      sh_d    = sh_q;
      armed_d = armed_q;
      if (tick && state_q != TXS_IDLE) begin
         cnt_d = bit_done ? '0 : cnt_q + 1'b1;
      end
      unique case (state_q)
         TXS_IDLE: begin
            if (go) begin
               state_d = TXS_START;
               sh_d    = ld_data;
               cnt_d   = '0;
            end
         end
         TXS_START: begin
            if (bit_done) begin
               state_d = TXS_DATA;
               idx_d   = '0;
            end
         end
         TXS_DATA: begin
            if (bit_done) begin
               sh_d  = sh_q >> 1;
               idx_d = idx_q + 1'b1;
               if (idx_q == IDX_LAST) begin
                  state_d = TXS_STOP;
               end
            end
         end
         TXS_STOP: begin
            if (bit_done) begin
               if (armed_q) begin
                  state_d = TXS_START;
                  armed_d = 1'b0;
               end else if (go) begin
                  state_d = TXS_START;
                  sh_d    = ld_data;
               end else begin
                  state_d = TXS_IDLE;
               end
            end
         end
         default: state_d = TXS_IDLE;
      endcase
      if (arm) begin
         sh_d    = ld_data;
         armed_d = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= TXS_IDLE;
         cnt_q   <= '0;
         idx_q   <= '0;
         sh_q    <= '0;
         armed_q <= 1'b0;
      end else begin
         state_q <= state_d;
         cnt_q   <= cnt_d;
         idx_q   <= idx_d;
         sh_q    <= sh_d;
         armed_q <= armed_d;
      end
   end

endmodule

// File: rtl/tx_hold_reg.sv
module tx_hold_reg #(
   parameter int DATA_W  = 8,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              put,
   input  logic              take,
   input  logic [DATA_W-1:0] put_data,
   output logic              full,
   output logic [DATA_W-1:0] data
);

   generate
      if (HOLD_EN) begin : g_hold
         logic              full_q;
         logic [DATA_W-1:0] data_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               full_q <= 1'b0;
               data_q <= '0;
            end else begin
               if (put) begin
                  full_q <= 1'b1;
                  data_q <= put_data;
               end else if (take) begin
                  full_q <= 1'b0;
               end
            end
         end
         assign full = full_q;
         assign data = data_q;
      end else begin : g_nohold
         logic unused_in;
         assign unused_in = ^{clk, rst_n, put, take, put_data};
         assign full = 1'b0;
         assign data = '0;
      end
   endgenerate

endmodule

// File: rtl/tx_irq_flag.sv
module tx_irq_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic lost,
   output logic flag,
   output logic lost_pulse
);

   logic flag_q, lost_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         lost_q <= 1'b0;
      end else begin
         if (set) begin
            flag_q <= 1'b1;
         end else if (clr) begin
            flag_q <= 1'b0;
         end
         lost_q <= lost;
      end
   end

   assign flag       = flag_q;
   assign lost_pulse = lost_q;

endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
   parameter int DATA_W  = 8,
   parameter int OVS     = 16,
   parameter bit HOLD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              baud_tick,
   input  logic              dbuf_en,
   input  logic              last_irq_en,
   input  logic              irq_at_end,
   input  logic              irq_clr,
   output logic              txd,
   output logic              tx_irq,
   output logic              busy,
   output logic              overrun
);

   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("dbuf_uart_tx: DATA_W must be at least 2");
      end
      if (OVS < 2) begin : g_bad_ovs
         $error("dbuf_uart_tx: OVS must be at least 2");
      end
   endgenerate

   logic              dbuf_on;
   logic              sh_idle, sh_stop_begin, sh_stop_end, sh_armed;
   logic              sh_free, hold_full;
   logic [DATA_W-1:0] hold_data, ld_data;
   logic              direct, put_hold, xfer_begin, xfer_end, go, lost;
   logic              last_evt, irq_set;

   assign dbuf_on = dbuf_en && HOLD_EN;

   // shifter can accept a new frame now or right at the end of its stop bit
   assign sh_free    = sh_idle || (sh_stop_end && !sh_armed);
   assign direct     = wr_en && sh_free && !hold_full;
   assign put_hold   = dbuf_on && wr_en && !direct;
   assign xfer_begin = !irq_at_end && sh_stop_begin && hold_full;
   assign xfer_end   = sh_stop_end && !sh_armed && hold_full;
   assign go         = direct || xfer_end;
   assign ld_data    = (xfer_begin || xfer_end) ? hold_data : wr_data;

   assign lost = dbuf_on ? (put_hold && hold_full && !(xfer_begin || xfer_end))
                         : (wr_en && !direct);

   assign last_evt = dbuf_on && last_irq_en && !hold_full &&
                     ((!irq_at_end && sh_stop_begin) ||
                      (irq_at_end && sh_stop_end && !sh_armed));

   assign irq_set = (dbuf_on && direct) || xfer_begin || xfer_end || last_evt ||
                    (!dbuf_on && sh_stop_end);

   tx_frame_shifter #(
      .DATA_W (DATA_W),
      .OVS    (OVS)
   ) u_shift (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (baud_tick),
      .go         (go),
      .arm        (xfer_begin),
      .ld_data    (ld_data),
      .txd        (txd),
      .idle       (sh_idle),
      .stop_begin (sh_stop_begin),
      .stop_end   (sh_stop_end),
      .armed      (sh_armed)
   );

   tx_hold_reg #(
      .DATA_W  (DATA_W),
      .HOLD_EN (HOLD_EN)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .put      (put_hold),
      .take     (xfer_begin || xfer_end),
      .put_data (wr_data),
      .full     (hold_full),
      .data     (hold_data)
   );

   tx_irq_flag u_irq (
      .clk        (clk),
      .rst_n      (rst_n),
      .set        (irq_set),
      .clr        (irq_clr),
      .lost       (lost),
      .flag       (tx_irq),
      .lost_pulse (overrun)
   );

   assign busy = !sh_idle || hold_full;

endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic wr_en,
   input logic dbuf_en,
   input logic irq_clr,
   input logic irq_set,
   input logic txd,
   input logic tx_irq,
   input logic busy,
   input logic overrun
);

   assert_direct_irq_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (dbuf_en && wr_en && !busy) |=> (tx_irq && !txd));

   assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

   assert_plain_no_early_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!dbuf_en && wr_en && !busy && !tx_irq) |=> !tx_irq);

   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_irq && !irq_clr) |=> tx_irq);

   assert_flag_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_clr && !irq_set) |=> !tx_irq);

   assert_overrun_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |-> $past(wr_en));

endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_en   (wr_en),
   .dbuf_en (dbuf_en),
   .irq_clr (irq_clr),
   .irq_set (irq_set),
   .txd     (txd),
   .tx_irq  (tx_irq),
   .busy    (busy),
   .overrun (overrun)
);

// File: tb/tb_dbuf_uart_tx.sv
module tb_dbuf_uart_tx;

   localparam int CLK_PERIOD = 10;
   localparam int FRAME = 160;
   localparam int STOPB = 144;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       baud_tick = 1'b1;
   logic       dbuf_en = 1'b1;
   logic       last_irq_en = 1'b0;
   logic       irq_at_end = 1'b0;
   logic       man_clr = 1'b0;
   logic       auto_clr = 1'b1;
   logic       auto_q = 1'b0;
   logic       irq_clr;
   logic       txd, tx_irq, busy, overrun;

   assign irq_clr = man_clr | auto_q;

   dbuf_uart_tx dut (
      .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_data (wr_data),
      .baud_tick (baud_tick), .dbuf_en (dbuf_en), .last_irq_en (last_irq_en),
      .irq_at_end (irq_at_end), .irq_clr (irq_clr), .txd (txd),
      .tx_irq (tx_irq), .busy (busy), .overrun (overrun)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int n_chk = 0, n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   // line decoder and flag-edge log, sampled on the falling edge
   int   rise_q[$];
   int   st_q[$];
   logic [7:0] rx_q[$];
   int   bad_bits = 0;
   bit   in_frame = 1'b0;
   bit   irq_prev = 1'b0;
   int   fstart = 0;
   logic [7:0] shv;

   always @(negedge clk) begin
      auto_q <= auto_clr && tx_irq;
      if (!rst_n) begin
         in_frame = 1'b0;
         irq_prev = 1'b0;
      end else begin
         if (tx_irq && !irq_prev) rise_q.push_back(cyc);
         irq_prev = tx_irq;
         if (!in_frame) begin
            if (!txd) begin
               in_frame = 1'b1;
               fstart = cyc;
               shv = 8'h00;
            end
         end else begin
            automatic int off = cyc - fstart;
            if (off % 16 == 8) begin
               automatic int k = off / 16;
               if (k == 0 && txd) bad_bits++;
               if (k >= 1 && k <= 8) shv[k-1] = txd;
               if (k == 9) begin
                  if (!txd) bad_bits++;
                  rx_q.push_back(shv);
                  st_q.push_back(fstart);
               end
            end
            if (off == FRAME - 1) in_frame = 1'b0;
         end
      end
   end

   task automatic check(bit ok, string req, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0;
      man_clr = 1'b0;
      rise_q.delete();
      st_q.delete();
      rx_q.delete();
      bad_bits = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic do_write(logic [7:0] d);
      wr_en = 1'b1;
      wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_quiet();
      do @(negedge clk); while (busy);
      repeat (40) @(negedge clk);
   endtask

   function automatic int evt_off(bit at_end);
      return at_end ? FRAME : STOPB;
   endfunction

   task automatic cmp_bytes(logic [7:0] exp[$], string req);
      check(rx_q.size() == exp.size(), req, rx_q.size(), exp.size());
      for (int i = 0; i < exp.size() && i < rx_q.size(); i++)
         check(rx_q[i] == exp[i], req, rx_q[i], exp[i]);
      check(bad_bits == 0, "R2 start/stop level", bad_bits, 0);
   endtask

   task automatic cmp_rises(int exp[$], string req);
      check(rise_q.size() == exp.size(), req, rise_q.size(), exp.size());
      for (int i = 0; i < exp.size() && i < rise_q.size(); i++)
         check(rise_q[i] == exp[i], req, rise_q[i], exp[i]);
   endtask

   // string of random bytes, next byte written after each flag event
   task automatic run_string(bit pos, bit last, int n);
      logic [7:0] bytes[$];
      int exp_r[$];
      do_reset();
      dbuf_en = 1'b1; irq_at_end = pos; last_irq_en = last; auto_clr = 1'b1;
      for (int i = 0; i < n; i++) bytes.push_back(8'($urandom));
      do_write(bytes[0]);
      check(tx_irq == 1'b1 && txd == 1'b0, "R1 direct load flag/start", {tx_irq, txd}, 2);
      for (int i = 1; i < n; i++) begin
         while (rise_q.size() < i) @(negedge clk);
         do_write(bytes[i]);
      end
      wait_quiet();
      cmp_bytes(bytes, "R2 R3 data order");
      for (int i = 1; i < st_q.size(); i++)
         check(st_q[i] == st_q[i-1] + FRAME, "R3 back to back", st_q[i] - st_q[i-1], FRAME);
      if (st_q.size() == n) begin
         exp_r.push_back(st_q[0]);
         for (int i = 0; i < n - 1; i++) exp_r.push_back(st_q[i] + evt_off(pos));
         if (last) exp_r.push_back(st_q[n-1] + evt_off(pos));
      end
      cmp_rises(exp_r, pos ? (last ? "R5 R7 flag timing" : "R5 R6 flag timing")
                           : (last ? "R4 R7 flag timing" : "R4 R6 flag timing"));
   endtask

   initial begin
      void'($urandom(32'd24681));

      // R12 reset state
      do_reset();
      check(txd == 1'b1, "R12 reset line high", txd, 1);
      check(tx_irq == 1'b0, "R12 reset flag clear", tx_irq, 0);
      check(busy == 1'b0, "R12 reset not busy", busy, 0);

      // R3-R7 all four select combinations, random lengths
      for (int c = 0; c < 4; c++) run_string(c[0], c[1], 2 + int'($urandom % 4));
      for (int c = 0; c < 2; c++) run_string(1'($urandom), 1'($urandom), 3);

      // R11 overwrite of the held byte
      begin
         logic [7:0] e[$];
         do_reset();
         dbuf_en = 1'b1; irq_at_end = 1'b0; last_irq_en = 1'b0; auto_clr = 1'b1;
         do_write(8'hA5);
         do_write(8'h3C);
         check(busy == 1'b1, "R12 busy while held", busy, 1);
         check(overrun == 1'b0, "R11 no overrun on first hold", overrun, 0);
         do_write(8'hC3);
         check(overrun == 1'b1, "R11 overrun pulse", overrun, 1);
         @(negedge clk);
         check(overrun == 1'b0, "R11 overrun one cycle", overrun, 0);
         wait_quiet();
         e = '{8'hA5, 8'hC3};
         cmp_bytes(e, "R11 held byte replaced");
      end

      // R8 plain mode
      begin
         logic [7:0] e[$];
         int er[$];
         do_reset();
         dbuf_en = 1'b0; irq_at_end = 1'($urandom); last_irq_en = 1'b1; auto_clr = 1'b1;
         do_write(8'h5A);
         check(tx_irq == 1'b0, "R8 no flag at load", tx_irq, 0);
         repeat (20) @(negedge clk);
         do_write(8'hFF);
         check(overrun == 1'b1, "R8 busy write dropped pulse", overrun, 1);
         wait_quiet();
         e = '{8'h5A};
         cmp_bytes(e, "R8 single frame");
         if (st_q.size() > 0) er.push_back(st_q[0] + FRAME);
         cmp_rises(er, "R8 flag at frame end");
      end

      // R9 write exactly as the last stop bit ends
      begin
         logic [7:0] e[$];
         int er[$];
         do_reset();
         dbuf_en = 1'b1; irq_at_end = 1'b1; last_irq_en = 1'b1; auto_clr = 1'b1;
         do_write(8'h81);
         while (st_q.size() < 1) @(negedge clk);
         while (cyc != st_q[0] + FRAME - 1) @(negedge clk);
         do_write(8'h7E);
         wait_quiet();
         e = '{8'h81, 8'h7E};
         cmp_bytes(e, "R9 boundary byte sent");
         if (st_q.size() == 2) begin
            check(st_q[1] == st_q[0] + FRAME, "R9 back to back", st_q[1] - st_q[0], FRAME);
            er = '{st_q[0], st_q[0] + FRAME, st_q[1] + FRAME};
         end
         cmp_rises(er, "R9 single event at boundary");
      end

      // R10 set and clear together, then clear alone
      do_reset();
      dbuf_en = 1'b1; auto_clr = 1'b0; last_irq_en = 1'b0; irq_at_end = 1'b0;
      man_clr = 1'b1;
      do_write(8'h11);
      man_clr = 1'b0;
      check(tx_irq == 1'b1, "R10 set wins over clear", tx_irq, 1);
      repeat (30) @(negedge clk);
      check(tx_irq == 1'b1, "R10 flag held", tx_irq, 1);
      man_clr = 1'b1;
      @(negedge clk);
      man_clr = 1'b0;
      check(tx_irq == 1'b0, "R10 cleared", tx_irq, 0);
      wait_quiet();
      check(tx_irq == 1'b0, "R6 no final event", tx_irq, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule